// File: doc/BRIEF.md
# Reversible Gate Cascade Evaluator

This block holds a short, programmable list of reversible gates and runs a bit pattern through them. Each list entry names one of three gate kinds: a multi-control inverter (Toffoli), a multi-control exchanger (Fredkin) or a Peres gate. Each entry also carries a mask that selects the control lines and two target line numbers. Software-side logic fills the list through a write port while the block is idle. It then sets how many entries are live and pulses start with an input pattern.

After the input is loaded, the block applies one gate per clock, either from the first entry to the last or from the last entry to the first. In the backward direction every gate is replaced by its inverse, so the cascade computes the inverse permutation. A backward run on a forward result gives back the original pattern. While it runs, the block counts the gates it applied and adds up their transistor cost. A malformed entry raises a sticky error flag and is skipped.

Top module: `rgc_cascade`

## Requirements
- R1: After reset, busy, done, err, data_out, gates_applied and tcost are all zero.
- R2: Kind code 0 (Toffoli) inverts line wr_ta when every line whose bit is set in the control mask (bit i = line i) is 1. With an empty mask it is an unconditional NOT.
- R3: Kind code 1 (Fredkin) exchanges lines wr_ta and wr_tb when every masked control line is 1. With an empty mask it always swaps.
- R4: Kind code 2 (Peres), with control condition c = AND of the masked lines, forward mode sets line ta to ta XOR (c AND tb) and line tb to tb XOR c. Both updates use the values present before the gate.
- R5: An entry is illegal if its kind code is 3, if a control bit is set on a target it uses, or if kind 1 or 2 names the same line twice. An illegal entry leaves the pattern unchanged, adds nothing to the counts, and sets err. err stays set until the next accepted start.
- R6: With reverse = 1, entries are applied from the last live one down to entry 0, and each Peres gate is applied as its inverse. A reverse run on a forward result returns the forward input.
- R7: done is a one-cycle pulse that comes exactly K+1 rising edges after the edge that accepts start, where K is the live gate count. busy is high from the accepting edge until done. data_out holds the result until the next accepted start.
- R8: gates_applied counts the legal gates applied. tcost sums 8 times the number of mask bits set, over those same gates.
- R9: Entries at an index of gate_total or above are not applied. A gate_total larger than the list depth acts as the full depth.
- R10: Writes to the list and start pulses that arrive while busy is high are ignored.
- R11: For any fixed list, distinct inputs give distinct forward outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one list entry |
| wr_addr | input | 4 | Entry index to write |
| wr_kind | input | 2 | Gate kind code: 0 Toffoli, 1 Fredkin, 2 Peres, 3 illegal |
| wr_ctrl | input | 8 | Control mask, bit i selects line i |
| wr_ta | input | 3 | First target line number |
| wr_tb | input | 3 | Second target line number (Fredkin, Peres) |
| gate_total | input | 5 | Number of live entries, sampled at start |
| reverse | input | 1 | Run backward with inverse gates, sampled at start |
| start | input | 1 | Begin a run when idle |
| data_in | input | 8 | Input pattern, sampled at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| data_out | output | 8 | Current or final pattern |
| err | output | 1 | An illegal entry was skipped in this run |
| gates_applied | output | 5 | Legal gates applied in this run |
| tcost | output | 11 | Accumulated transistor cost of this run |

## Verification
The bench uses the default build of 8 lines and a 16-entry list. At this size the inverse of each gate can be found by an exhaustive search over all 256 patterns, and one fixed cascade can be swept over its whole input space to show it is a permutation. The full depth is also small enough to exercise the clamp of an oversize gate_total, and random lists are long enough to mix legal and illegal entries.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  typedef enum logic [1:0] {
    GK_TOFFOLI = 2'd0,
    GK_FREDKIN = 2'd1,
    GK_PERES   = 2'd2,
    GK_BAD     = 2'd3
  } gate_kind_e;
endpackage

// File: rtl/rgc_gate_mem.sv
module rgc_gate_mem #(
  parameter int N     = 8,
  parameter int DEPTH = 16,
  parameter int IW    = 3,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  rgc_pkg::gate_kind_e wkind,
  input  logic [N-1:0]        wctrl,
  input  logic [IW-1:0]       wta,
  input  logic [IW-1:0]       wtb,
  input  logic [AW-1:0]       raddr,
  output rgc_pkg::gate_kind_e rkind,
  output logic [N-1:0]        rctrl,
  output logic [IW-1:0]       rta,
  output logic [IW-1:0]       rtb
);
  rgc_pkg::gate_kind_e kind_q [DEPTH];
  logic [N-1:0]        ctrl_q [DEPTH];
  logic [IW-1:0]       ta_q   [DEPTH];
  logic [IW-1:0]       tb_q   [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= rgc_pkg::GK_TOFFOLI;
        ctrl_q[i] <= '0;
        ta_q[i]   <= '0;
        tb_q[i]   <= '0;
      end
    end else if (we) begin
      kind_q[waddr] <= wkind;
      ctrl_q[waddr] <= wctrl;
      ta_q[waddr]   <= wta;
      tb_q[waddr]   <= wtb;
    end
  end

  assign rkind = kind_q[raddr];
  assign rctrl = ctrl_q[raddr];
  assign rta   = ta_q[raddr];
  assign rtb   = tb_q[raddr];
endmodule

// File: rtl/rgc_gate_unit.sv
module rgc_gate_unit #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int CW = 11
) (
  input  logic [N-1:0]        vec_i,
  input  rgc_pkg::gate_kind_e kind,
  input  logic [N-1:0]        ctrl,
  input  logic [IW-1:0]       ta,
  input  logic [IW-1:0]       tb,
  input  logic                inverse,
  output logic [N-1:0]        vec_o,
  output logic                illegal,
  output logic [CW-1:0]       cost_o
);
  localparam bit FULL_RANGE = ((1 << IW) == N);

  function automatic logic controls_met(input logic [N-1:0] v, input logic [N-1:0] m);
    return &(v | ~m);
  endfunction

  function automatic int mask_weight(input logic [N-1:0] m);
    int w = 0;
    for (int i = 0; i < N; i++) w += int'(m[i]);
    return w;
  endfunction

  logic ta_ok, tb_ok, fire;

  always_comb begin
    ta_ok = FULL_RANGE ? 1'b1 : (int'(ta) < N);
    tb_ok = FULL_RANGE ? 1'b1 : (int'(tb) < N);
    fire  = controls_met(vec_i, ctrl);
    vec_o = vec_i;
    unique case (kind)
      rgc_pkg::GK_TOFFOLI: begin
        illegal = !ta_ok || ctrl[ta];
        if (!illegal && fire) vec_o[ta] = ~vec_i[ta];
      end
      rgc_pkg::GK_FREDKIN: begin
        illegal = !ta_ok || !tb_ok || (ta == tb) || ctrl[ta] || ctrl[tb];
        if (!illegal && fire) begin
          vec_o[ta] = vec_i[tb];
          vec_o[tb] = vec_i[ta];
        end
      end
      rgc_pkg::GK_PERES: begin
        illegal = !ta_ok || !tb_ok || (ta == tb) || ctrl[ta] || ctrl[tb];
        if (!illegal) begin
          vec_o[tb] = vec_i[tb] ^ fire;
          if (!inverse) vec_o[ta] = vec_i[ta] ^ (fire & vec_i[tb]);
          else          vec_o[ta] = vec_i[ta] ^ (fire & (vec_i[tb] ^ fire));
        end
      end
      default: illegal = 1'b1;
    endcase
    cost_o = illegal ? '0 : CW'(8 * mask_weight(ctrl));
  end
endmodule

// File: rtl/rgc_seq.sv
module rgc_seq #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CNTW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CNTW-1:0] gate_total,
  input  logic            reverse,
  output logic            busy,
  output logic            done,
  output logic            load,
  output logic            step_fire,
  output logic            rev_q,
  output logic [AW-1:0]   gate_idx
);
  logic            busy_q, done_q;
  logic [CNTW-1:0] step_q, total_q, eff_total, back_idx;
  logic            finish;

  assign load      = start && !busy_q;
  assign eff_total = (gate_total > CNTW'(DEPTH)) ? CNTW'(DEPTH) : gate_total;
  assign finish    = busy_q && (step_q == total_q);
  assign step_fire = busy_q && (step_q != total_q);
  assign back_idx  = total_q - step_q - CNTW'(1);
  assign gate_idx  = rev_q ? back_idx[AW-1:0] : step_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      total_q <= '0;
      rev_q   <= 1'b0;
    end else if (load) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      step_q  <= '0;
      total_q <= eff_total;
      rev_q   <= reverse;
    end else if (finish) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (step_fire) step_q <= step_q + CNTW'(1);
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/rgc_cascade.sv
module rgc_cascade #(
  parameter int N_LINES = 8,
  parameter int DEPTH   = 16,
  localparam int IW     = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW   = AW + 1,
  localparam int CW     = $clog2(8 * N_LINES * DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [1:0]         wr_kind,
  input  logic [N_LINES-1:0] wr_ctrl,
  input  logic [IW-1:0]      wr_ta,
  input  logic [IW-1:0]      wr_tb,
  input  logic [CNTW-1:0]    gate_total,
  input  logic               reverse,
  input  logic               start,
  input  logic [N_LINES-1:0] data_in,
  output logic               busy,
  output logic               done,
  output logic [N_LINES-1:0] data_out,
  output logic               err,
  output logic [CNTW-1:0]    gates_applied,
  output logic [CW-1:0]      tcost
);
  logic                mem_we, load, step_fire, rev_q, gate_illegal;
  logic [AW-1:0]       gate_idx;
  rgc_pkg::gate_kind_e g_kind;
  logic [N_LINES-1:0]  g_ctrl, state_q, next_vec;
  logic [IW-1:0]       g_ta, g_tb;
  logic [CW-1:0]       g_cost, cost_q;
  logic [CNTW-1:0]     applied_q;
  logic                err_q;

  assign mem_we = wr_en && !busy;

  rgc_gate_mem #(.N(N_LINES), .DEPTH(DEPTH), .IW(IW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(wr_addr),
    .wkind(rgc_pkg::gate_kind_e'(wr_kind)), .wctrl(wr_ctrl), .wta(wr_ta), .wtb(wr_tb),
    .raddr(gate_idx), .rkind(g_kind), .rctrl(g_ctrl), .rta(g_ta), .rtb(g_tb)
  );

  rgc_seq #(.DEPTH(DEPTH), .AW(AW), .CNTW(CNTW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_total(gate_total),
    .reverse(reverse), .busy(busy), .done(done), .load(load),
    .step_fire(step_fire), .rev_q(rev_q), .gate_idx(gate_idx)
  );

  rgc_gate_unit #(.N(N_LINES), .IW(IW), .CW(CW)) u_unit (
    .vec_i(state_q), .kind(g_kind), .ctrl(g_ctrl), .ta(g_ta), .tb(g_tb),
    .inverse(rev_q), .vec_o(next_vec), .illegal(gate_illegal), .cost_o(g_cost)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= '0;
      err_q     <= 1'b0;
      applied_q <= '0;
      cost_q    <= '0;
    end else if (load) begin
      state_q   <= data_in;
      err_q     <= 1'b0;
      applied_q <= '0;
      cost_q    <= '0;
    end else if (step_fire) begin
      state_q <= next_vec;
      if (gate_illegal) err_q <= 1'b1;
      else begin
        applied_q <= applied_q + CNTW'(1);
        cost_q    <= cost_q + g_cost;
      end
    end
  end

  assign data_out      = state_q;
  assign err           = err_q;
  assign gates_applied = applied_q;
  assign tcost         = cost_q;
endmodule

// File: rtl/rgc_checker.sv
module rgc_checker #(
  parameter int N    = 8,
  parameter int CNTW = 5,
  parameter int CW   = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [N-1:0]    data_out,
  input logic            err,
  input logic [CW-1:0]   tcost,
  input logic            step_fire,
  input logic            gate_illegal
);
  assert_done_excl_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(data_out));
  assert_skip_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && gate_illegal) |=> ($stable(data_out) && err));
  assert_cost_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (tcost >= $past(tcost)));
endmodule

bind rgc_cascade rgc_checker #(.N(N_LINES), .CNTW(CNTW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .data_out(data_out), .err(err), .tcost(tcost),
  .step_fire(step_fire), .gate_illegal(gate_illegal)
);

// File: tb/tb_rgc_cascade.sv
module tb_rgc_cascade;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [1:0]  wr_kind = '0;
  logic [7:0]  wr_ctrl = '0;
  logic [2:0]  wr_ta = '0, wr_tb = '0;
  logic [4:0]  gate_total = '0;
  logic        reverse = 1'b0, start = 1'b0;
  logic [7:0]  data_in = '0;
  logic        busy, done, err;
  logic [7:0]  data_out;
  logic [4:0]  gates_applied;
  logic [10:0] tcost;

  int checks = 0, fails = 0, cyc = 0;
  int m_kind[16], m_ctrl[16], m_ta[16], m_tb[16];

  always #4 clk = ~clk;

  rgc_cascade dut (.*);

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit legal(int k, int c, int a, int b);
    if (k == 3) return 0;
    if (c[a]) return 0;
    if (k != 0 && (a == b || c[b])) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] fwd_gate(logic [7:0] v, int k, int c, int a, int b);
    logic [7:0] r = v;
    bit fire = 1;
    for (int i = 0; i < 8; i++) if (c[i] && !v[i]) fire = 0;
    case (k)
      0: if (fire) r[a] = !v[a];
      1: if (fire) begin r[a] = v[b]; r[b] = v[a]; end
      2: begin
        if (fire && v[b]) r[a] = !v[a];
        if (fire) r[b] = !v[b];
      end
      default: r = v;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] inv_gate(logic [7:0] y, int k, int c, int a, int b);
    for (int x = 0; x < 256; x++)
      if (fwd_gate(8'(x), k, c, a, b) == y) return 8'(x);
    return 8'hxx;
  endfunction

  task automatic wr(input int idx, input int k, input int c, input int a, input int b, input bit track);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(idx); wr_kind = 2'(k); wr_ctrl = 8'(c); wr_ta = 3'(a); wr_tb = 3'(b);
    @(negedge clk);
    wr_en = 0;
    if (track) begin m_kind[idx] = k; m_ctrl[idx] = c; m_ta[idx] = a; m_tb[idx] = b; end
  endtask

  // Runs the cascade, checks R2-R9 outcome and latency; poke tests R10.
  task automatic run(input logic [7:0] din, input bit rev, input int cnt, input bit poke,
                     output logic [7:0] got);
    int eff = (cnt > 16) ? 16 : cnt;
    logic [7:0] v = din;
    bit e = 0;
    int napp = 0, cost = 0, lat = 0;
    for (int s = 0; s < eff; s++) begin
      int i = rev ? eff - 1 - s : s;
      if (!legal(m_kind[i], m_ctrl[i], m_ta[i], m_tb[i])) e = 1;
      else begin
        v = rev ? inv_gate(v, m_kind[i], m_ctrl[i], m_ta[i], m_tb[i])
                : fwd_gate(v, m_kind[i], m_ctrl[i], m_ta[i], m_tb[i]);
        napp++;
        cost += 8 * $countones(8'(m_ctrl[i]));
      end
    end
    @(negedge clk);
    data_in = din; reverse = rev; gate_total = 5'(cnt); start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      start = 1; wr_en = 1; wr_addr = 0; wr_kind = 2'd0; wr_ctrl = 8'h00; wr_ta = 3'd7;
      data_in = ~din;
    end
    while (1) begin
      @(negedge clk);
      lat++;
      start = 0; wr_en = 0;
      if (done || lat > 60) break;
    end
    got = data_out;
    chk(lat == eff + 1, "R7 latency", lat, eff + 1);
    chk(data_out == v, rev ? "R6 reverse result" : "R2/R3/R4/R9 forward result", data_out, v);
    chk(err == e, "R5 err flag", err, e);
    chk(gates_applied == 5'(napp), "R8 gate count", gates_applied, napp);
    chk(tcost == 11'(cost), "R8 transistor cost", tcost, cost);
  endtask

  logic [7:0] o, o2;
  bit seen[256];
  int dup;
  int unsigned r;

  initial begin
    r = $urandom(32'd2024);
    for (int i = 0; i < 16; i++) begin m_kind[i] = 0; m_ctrl[i] = 0; m_ta[i] = 0; m_tb[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err, "R1 flags", {busy, done, err}, 0);
    chk(data_out == 0 && gates_applied == 0 && tcost == 0, "R1 data", data_out, 0);

    // R2: NOT on line 3, then CNOT 0->5, then 3-control Toffoli
    wr(0, 0, 8'h00, 3, 0, 1);
    run(8'h00, 0, 1, 0, o);
    chk(o == 8'h08, "R2 NOT", o, 8'h08);
    wr(0, 0, 8'h01, 5, 0, 1);
    run(8'h01, 0, 1, 0, o);
    chk(o == 8'h21, "R2 CNOT fire", o, 8'h21);
    run(8'h00, 0, 1, 0, o);
    chk(o == 8'h00, "R2 CNOT idle", o, 8'h00);
    wr(0, 0, 8'h07, 7, 0, 1);
    run(8'h07, 0, 1, 0, o);
    chk(o == 8'h87, "R2 3-control", o, 8'h87);
    run(8'h05, 0, 1, 0, o);
    chk(o == 8'h05, "R2 partial controls", o, 8'h05);

    // R3: swap lines 1,6 under control of line 0
    wr(0, 1, 8'h01, 1, 6, 1);
    run(8'h03, 0, 1, 0, o);
    chk(o == 8'h41, "R3 swap fire", o, 8'h41);
    run(8'h02, 0, 1, 0, o);
    chk(o == 8'h02, "R3 swap idle", o, 8'h02);

    // R4: Peres control 0, ta 1, tb 2: 101 -> 011
    wr(0, 2, 8'h01, 1, 2, 1);
    run(8'h05, 0, 1, 0, o);
    chk(o == 8'h03, "R4 Peres", o, 8'h03);
    run(o, 1, 1, 0, o2);
    chk(o2 == 8'h05, "R6 Peres inverse", o2, 8'h05);

    // R5: illegal entries skipped
    wr(0, 0, 8'h08, 3, 0, 1);
    wr(1, 1, 8'h00, 4, 4, 1);
    wr(2, 3, 8'h00, 0, 1, 1);
    wr(3, 0, 8'h00, 0, 0, 1);
    run(8'h5A, 0, 4, 0, o);
    chk(o == 8'h5B && err, "R5 skip", o, 8'h5B);
    run(8'h5A, 0, 0, 0, o);
    chk(!err && o == 8'h5A, "R9/R5 empty run clears err", o, 8'h5A);
    run(8'h5A, 0, 3, 0, o);
    chk(o == 8'h5A, "R9 entry 3 beyond count", o, 8'h5A);

    // R9 clamp: fill all 16, total 20
    for (int i = 0; i < 16; i++) wr(i, 0, 0, i % 8, 0, 1);
    run(8'h00, 0, 20, 0, o);
    chk(o == 8'h00, "R9 clamp", o, 8'h00);

    // R10: write and start during busy ignored
    wr(0, 0, 8'h00, 2, 0, 1);
    run(8'h10, 0, 4, 1, o);
    repeat (3) @(negedge clk);
    chk(!busy, "R10 start while busy ignored", busy, 0);
    run(8'h10, 0, 4, 0, o);

    // Random cascades, forward then reverse (R6, R8)
    for (int t = 0; t < 40; t++) begin
      int k = $urandom % 17;
      logic [7:0] din = 8'($urandom);
      for (int i = 0; i < 16; i++)
        wr(i, ($urandom % 8 == 0) ? 3 : $urandom % 3, $urandom & $urandom & $urandom,
           $urandom % 8, $urandom % 8, 1);
      run(din, 0, k, 0, o);
      run(o, 1, k, 0, o2);
      chk(o2 == din, "R6 round trip", o2, din);
    end

    // R11: full sweep of one cascade
    for (int i = 0; i < 10; i++) wr(i, i % 3, (i % 3 == 0) ? 8'h30 : 8'h01, 2 + (i % 2), 6 + (i % 2), 1);
    dup = 0;
    for (int x = 0; x < 256; x++) seen[x] = 0;
    for (int x = 0; x < 256; x++) begin
      run(8'(x), 0, 10, 0, o);
      if (seen[o]) dup++;
      seen[o] = 1;
    end
    chk(dup == 0, "R11 bijection", dup, 0);

    summary();
  end
endmodule